// File: doc/BRIEF.md
# ATA Programmed-I/O Bus Cycle Timer

This block runs one parallel ATA programmed-I/O cycle at a time toward an attached drive. A request gives the direction, a 3-bit register address, a choice of one of two chip selects, and a width. The width is either an 8-bit taskfile byte or a 16-bit data word. A write also carries its data. The block holds chip select and address valid across the whole cycle. It opens the read or write strobe only in the middle phase of the cycle and releases everything once the recovery time has passed. It then pulses `done` for one clock, and after a read it also presents the captured data.

Three timing fields in a timing word set the phase lengths, all counted in controller clocks: setup, strobe-active and recovery. A control word holds two switches. One lets the drive's ready line stretch the strobe. The other byte-swaps 16-bit words for little-endian operation. The timing and control words are latched when a request is accepted, so software may change them while a cycle is in flight.

Top module: `ata_pio_timer`

## Requirements
- R1: A request (`req_valid` high) is accepted only while `busy` is low. `busy` is high from the clock after acceptance until the clock on which `done` rises. `done` is a single-cycle pulse. A request presented while `busy` is high is dropped and produces no bus cycle.
- R2: `cfg_timing[3:0]` is the setup length, `cfg_timing[11:4]` the active length and `cfg_timing[19:12]` the recovery length, all in clocks. Each phase lasts exactly that many clocks.
- R3: A timing field of zero gives a phase of one clock.
- R4: The phases run in order: setup with chip select and address valid and both strobes high, then active with one strobe low (`ata_rd_n` for reads, `ata_wr_n` for writes), then recovery with the strobes high and chip select still valid. `req_cs`=0 drives `ata_cs_n`=2'b10 and `req_cs`=1 drives `ata_cs_n`=2'b01. Both lines are high when idle.
- R5: When `cfg_ctrl[1]` is set, the active phase is held at its final clock while the synchronized `ata_iordy` is low. The line passes two flops, so a rise seen in active clock K ends the strobe after clock max(active length, K+2).
- R6: When `cfg_ctrl[1]` is clear, `ata_iordy` has no effect on any phase length.
- R7: With `req_wide`=1 and `cfg_ctrl[6]` set, the two bytes of the 16-bit word are exchanged in both directions. With `cfg_ctrl[6]` clear they pass unchanged.
- R8: With `req_wide`=0, only bits [7:0] are used. On a write `ata_dout`=`{8'h00, req_wdata[7:0]}`, and on a read `rdata`=`{8'h00, ata_din[7:0]}`. `cfg_ctrl[6]` is ignored.
- R9: Read data is sampled on the last clock of the active phase. `rdata` holds that value until the next read.
- R10: `ata_doe` is high only in write cycles, from the first setup clock through the last active clock.
- R11: After reset `busy`, `done` and `ata_doe` are low, and `ata_cs_n`=2'b11, `ata_rd_n`=1 and `ata_wr_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_cs | input | 1 | Chip-select choice: 0 command block, 1 control block |
| req_addr | input | 3 | Register address on the bus |
| req_wide | input | 1 | 1 = 16-bit data word, 0 = 8-bit taskfile byte |
| req_wdata | input | 16 | Write data |
| cfg_timing | input | 20 | Setup [3:0], active [11:4], recovery [19:12] |
| cfg_ctrl | input | 8 | Bit 1 ready-wait enable, bit 6 byte swap |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock pulse at end of cycle |
| rdata | output | 16 | Last captured read data |
| ata_cs_n | output | 2 | Chip selects, active low |
| ata_addr | output | 3 | Register address lines |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_doe | output | 1 | Data bus drive enable |
| ata_dout | output | 16 | Data driven to the bus |
| ata_din | input | 16 | Data read from the bus |
| ata_iordy | input | 1 | Drive ready line, asynchronous |

## Verification
The assertions assume that `ata_din` is stable through the last active clock of a read. They also assume that the ready line, when waiting is enabled, rises at some point so that a cycle can end. The bench drive model holds the read value fixed for the whole transaction. It raises the ready line after a chosen number of active clocks, or keeps it high. The bench holds the line low indefinitely only when waiting is disabled, and that is the case that shows the line is ignored. Requests presented during a busy cycle differ in direction, address and data from the accepted one, so any wrongly taken request shows up in the scoreboard as an extra completion.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;
endpackage

// File: rtl/ata_sync2.sv
module ata_sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/ata_byte_lane.sv
// Width and endianness steering for one data direction.
module ata_byte_lane #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] din,
  input  logic          wide,
  input  logic          swap,
  output logic [DW-1:0] dout
);
  localparam int NB = DW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    if (b == 0) begin : g_low
      assign dout[7:0] = (wide && swap) ? din[(NB-1)*8 +: 8] : din[7:0];
    end else begin : g_high
      assign dout[b*8 +: 8] = !wide ? 8'h00 :
                              swap  ? din[(NB-1-b)*8 +: 8] : din[b*8 +: 8];
    end
  end
endmodule

// File: rtl/ata_phase_seq.sv
// Three-phase cycle sequencer with a stall on the final active clock.
module ata_phase_seq
  import ata_pio_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             hold,
  input  logic [CNT_W-1:0] setup_len,
  input  logic [CNT_W-1:0] act_len,
  input  logic [CNT_W-1:0] rec_len,
  output phase_e           phase,
  output logic             step_end
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur_len;
  logic             at_last;

  always_comb begin
    unique case (phase)
      PH_SETUP:  cur_len = setup_len;
      PH_ACTIVE: cur_len = act_len;
      PH_RECOV:  cur_len = rec_len;
      default:   cur_len = CNT_W'(1);
    endcase
  end

  assign at_last  = (cnt == cur_len - CNT_W'(1));
  assign step_end = (phase != PH_IDLE) && at_last &&
                    !((phase == PH_ACTIVE) && hold);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (start) phase <= PH_SETUP;
        end
        default: begin
          if (!at_last) begin
            cnt <= cnt + CNT_W'(1);
          end else if (step_end) begin
            cnt <= '0;
            unique case (phase)
              PH_SETUP:  phase <= PH_ACTIVE;
              PH_ACTIVE: phase <= PH_RECOV;
              default:   phase <= PH_IDLE;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
  import ata_pio_pkg::*;
#(
  parameter int DW        = 16,
  parameter int AW        = 3,
  parameter int NCS       = 2,
  parameter int SETUP_W   = 4,
  parameter int ACT_W     = 8,
  parameter int REC_W     = 8,
  parameter int CTRL_W    = 8,
  parameter int IORDY_BIT = 1,
  parameter int SWAP_BIT  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [$clog2(NCS)-1:0]  req_cs,
  input  logic [AW-1:0]           req_addr,
  input  logic                    req_wide,
  input  logic [DW-1:0]           req_wdata,
  input  logic [SETUP_W+ACT_W+REC_W-1:0] cfg_timing,
  input  logic [CTRL_W-1:0]       cfg_ctrl,
  output logic                    busy,
  output logic                    done,
  output logic [DW-1:0]           rdata,
  output logic [NCS-1:0]          ata_cs_n,
  output logic [AW-1:0]           ata_addr,
  output logic                    ata_rd_n,
  output logic                    ata_wr_n,
  output logic                    ata_doe,
  output logic [DW-1:0]           ata_dout,
  input  logic [DW-1:0]           ata_din,
  input  logic                    ata_iordy
);
  localparam int TIM_W     = SETUP_W + ACT_W + REC_W;
  localparam int SETUP_LSB = 0;
  localparam int ACT_LSB   = SETUP_LSB + SETUP_W;
  localparam int REC_LSB   = ACT_LSB + ACT_W;
  localparam int MAX_SA    = (SETUP_W > ACT_W) ? SETUP_W : ACT_W;
  localparam int CNT_W     = (MAX_SA > REC_W) ? MAX_SA : REC_W;

  logic [TIM_W-1:0] lat_tim;
  logic             lat_write, lat_wide, lat_swap, lat_wait_en;
  logic             iordy_s;
  logic             accept, hold, step_end;
  logic             setup_end, active_end, recov_end;
  phase_e           phase;
  logic [CNT_W-1:0] setup_len, act_len, rec_len;
  logic [DW-1:0]    wr_lane, rd_lane;
  logic             ctrl_unused_bits;

  assign ctrl_unused_bits = ^cfg_ctrl;

  // Zero fields become one-clock phases.
  always_comb begin
    setup_len = CNT_W'(lat_tim[SETUP_LSB +: SETUP_W]);
    act_len   = CNT_W'(lat_tim[ACT_LSB +: ACT_W]);
    rec_len   = CNT_W'(lat_tim[REC_LSB +: REC_W]);
    if (setup_len == '0) setup_len = CNT_W'(1);
    if (act_len == '0)   act_len   = CNT_W'(1);
    if (rec_len == '0)   rec_len   = CNT_W'(1);
  end

  ata_sync2 #(.W(1), .RST_VAL(1'b1)) u_rdy_sync (
    .clk (clk), .rst (rst), .d (ata_iordy), .q (iordy_s)
  );

  assign accept = req_valid && !busy;
  assign hold   = lat_wait_en && !iordy_s;

  ata_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .hold      (hold),
    .setup_len (setup_len),
    .act_len   (act_len),
    .rec_len   (rec_len),
    .phase     (phase),
    .step_end  (step_end)
  );

  assign setup_end  = step_end && (phase == PH_SETUP);
  assign active_end = step_end && (phase == PH_ACTIVE);
  assign recov_end  = step_end && (phase == PH_RECOV);

  ata_byte_lane #(.DW(DW)) u_wr_lane (
    .din (req_wdata), .wide (req_wide), .swap (cfg_ctrl[SWAP_BIT]), .dout (wr_lane)
  );

  ata_byte_lane #(.DW(DW)) u_rd_lane (
    .din (ata_din), .wide (lat_wide), .swap (lat_swap), .dout (rd_lane)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      rdata       <= '0;
      ata_cs_n    <= '1;
      ata_addr    <= '0;
      ata_rd_n    <= 1'b1;
      ata_wr_n    <= 1'b1;
      ata_doe     <= 1'b0;
      ata_dout    <= '0;
      lat_tim     <= '0;
      lat_write   <= 1'b0;
      lat_wide    <= 1'b0;
      lat_swap    <= 1'b0;
      lat_wait_en <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy        <= 1'b1;
        lat_tim     <= cfg_timing;
        lat_write   <= req_write;
        lat_wide    <= req_wide;
        lat_swap    <= cfg_ctrl[SWAP_BIT];
        lat_wait_en <= cfg_ctrl[IORDY_BIT];
        ata_cs_n    <= ~(NCS'(1) << req_cs);
        ata_addr    <= req_addr;
        ata_doe     <= req_write;
        if (req_write) ata_dout <= wr_lane;
      end
      if (setup_end) begin
        ata_rd_n <= lat_write;
        ata_wr_n <= !lat_write;
      end
      if (active_end) begin
        ata_rd_n <= 1'b1;
        ata_wr_n <= 1'b1;
        ata_doe  <= 1'b0;
        if (!lat_write) rdata <= rd_lane;
      end
      if (recov_end) begin
        ata_cs_n <= '1;
        busy     <= 1'b0;
        done     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ata_pio_timer_chk.sv
module ata_pio_timer_chk #(
  parameter int DW  = 16,
  parameter int NCS = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] rdata,
  input logic [NCS-1:0] ata_cs_n,
  input logic          ata_rd_n,
  input logic          ata_wr_n,
  input logic          ata_doe
);
  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid) |=> busy);
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!ata_rd_n && !ata_wr_n));
  // R4
  strobe_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (!ata_rd_n || !ata_wr_n) |-> (ata_cs_n != '1));
  // R4
  cs_single_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~ata_cs_n) <= 1);
  // R10
  doe_dir_chk: assert property (@(posedge clk) disable iff (rst)
    ata_doe |-> ata_rd_n);
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(ata_rd_n) |-> $stable(rdata));
endmodule

bind ata_pio_timer ata_pio_timer_chk #(.DW(DW), .NCS(NCS)) u_chk (.*);

// File: tb/sim_ata_pio_timer.sv
module sim_ata_pio_timer;
  localparam int CLK_P = 10;

  typedef struct {
    bit        wr;
    bit [1:0]  csn;
    bit [2:0]  addr;
    bit [15:0] data;
    int        su, ac, rc;
    string     tl, td;
  } exp_t;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_cs = 0, req_wide = 0;
  logic [2:0]  req_addr = 0;
  logic [15:0] req_wdata = 0, ata_din = 0;
  logic [19:0] cfg_timing = 0;
  logic [7:0]  cfg_ctrl = 0;
  logic ata_iordy = 1;
  logic busy, done, ata_rd_n, ata_wr_n, ata_doe;
  logic [15:0] rdata, ata_dout;
  logic [1:0]  ata_cs_n;
  logic [2:0]  ata_addr;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0, n_done = 0;
  int stall_k = 0;
  bit iordy_idle = 1;
  bit finished = 0;
  int su_c = 0, ac_c = 0, rc_c = 0;
  bit seen = 0, doe_bad = 0;
  bit [1:0] o_csn; bit [2:0] o_addr; bit [15:0] o_dout; bit o_wr;

  always #(CLK_P/2) clk = ~clk;

  ata_pio_timer u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_wide(req_wide),
    .req_wdata(req_wdata), .cfg_timing(cfg_timing), .cfg_ctrl(cfg_ctrl),
    .busy(busy), .done(done), .rdata(rdata), .ata_cs_n(ata_cs_n),
    .ata_addr(ata_addr), .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n),
    .ata_doe(ata_doe), .ata_dout(ata_dout), .ata_din(ata_din),
    .ata_iordy(ata_iordy)
  );

  task automatic chk(string tag, int actv, int expv);
    n_chk++;
    if (actv != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actv, expv);
    end
  endtask

  function automatic int nz(int x);
    return (x == 0) ? 1 : x;
  endfunction

  // Driver: pushes the expected item, then issues the request.
  task automatic xfer(bit wr, bit cs, bit [2:0] addr, bit wide, bit [15:0] wd,
                      bit [15:0] dv, int t1, int t2, int t3, bit ien, bit sw,
                      int stall, bit idle_lvl, bit poke, string tl, string td);
    exp_t e;
    bit [15:0] v;
    int target;
    v = wr ? wd : dv;
    e.wr = wr; e.csn = cs ? 2'b01 : 2'b10; e.addr = addr;
    e.data = !wide ? {8'h00, v[7:0]} : (sw ? {v[7:0], v[15:8]} : v);
    e.su = nz(t1); e.ac = nz(t2); e.rc = nz(t3);
    if (ien && stall > 0 && stall + 2 > e.ac) e.ac = stall + 2;
    e.tl = tl; e.td = td;
    @(negedge clk);
    while (busy) @(negedge clk);
    cfg_timing = {t3[7:0], t2[7:0], t1[3:0]};
    cfg_ctrl = 8'(({7'b0, ien} << 1) | ({7'b0, sw} << 6));
    ata_din = dv; stall_k = stall; iordy_idle = idle_lvl;
    exp_q.push_back(e);
    target = n_done + 1;
    @(negedge clk);
    req_write = wr; req_cs = cs; req_addr = addr; req_wide = wide;
    req_wdata = wd; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R1 busy after accept", int'(busy), 1);
    if (poke) begin
      req_valid = 1; req_write = !wr; req_addr = ~addr; req_wdata = ~wd;
      cfg_timing = 20'h0;
      @(negedge clk);
      @(negedge clk);
      req_valid = 0;
    end
    while (n_done < target) @(negedge clk);
    stall_k = 0; iordy_idle = 1;
  endtask

  // Monitor and drive model: measures phases, compares at done.
  always @(negedge clk) begin
    if (rst) begin
      su_c = 0; ac_c = 0; rc_c = 0; seen = 0; doe_bad = 0;
    end else begin
      if (ata_cs_n != 2'b11) begin
        if (ata_rd_n && ata_wr_n) begin
          if (!seen) begin
            su_c++;
            if (exp_q.size() > 0 && ata_doe !== exp_q[0].wr) doe_bad = 1;
          end else begin
            rc_c++;
            if (ata_doe) doe_bad = 1;
          end
        end else begin
          ac_c++; seen = 1;
          o_csn = ata_cs_n; o_addr = ata_addr; o_dout = ata_dout; o_wr = !ata_wr_n;
          if (ata_doe !== o_wr) doe_bad = 1;
        end
      end else if (ata_doe) begin
        doe_bad = 1;
      end
      if (done) begin
        if (exp_q.size() == 0) begin
          chk("R1 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk("R1 busy low at done", int'(busy), 0);
          chk({e.tl, " setup len"}, su_c, e.su);
          chk({e.tl, " active len"}, ac_c, e.ac);
          chk({e.tl, " recovery len"}, rc_c, e.rc);
          chk("R4 chip select", int'(o_csn), int'(e.csn));
          chk("R4 address", int'(o_addr), int'(e.addr));
          chk("R4 strobe direction", int'(o_wr), int'(e.wr));
          chk("R10 doe window", int'(doe_bad), 0);
          if (e.wr) chk({e.td, " write bus data"}, int'(o_dout), int'(e.data));
          else      chk({e.td, " read data"}, int'(rdata), int'(e.data));
        end
        su_c = 0; ac_c = 0; rc_c = 0; seen = 0; doe_bad = 0;
        n_done++;
      end
      if (stall_k == 0) ata_iordy = iordy_idle;
      else              ata_iordy = (ac_c >= stall_k);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL R1 watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 busy", int'(busy), 0);
    chk("R11 done", int'(done), 0);
    chk("R11 cs_n", int'(ata_cs_n), 3);
    chk("R11 rd_n", int'(ata_rd_n), 1);
    chk("R11 wr_n", int'(ata_wr_n), 1);
    chk("R11 doe", int'(ata_doe), 0);
    rst = 0;
    //   wr cs addr wide  wdata     din     t1 t2 t3 ien sw stall idle poke
    xfer(1, 0, 3'd0, 1, 16'h1234, 16'h0000, 2, 3, 2, 0, 0, 0, 1, 0, "R2", "R7");
    xfer(0, 0, 3'd0, 1, 16'h0000, 16'hC3A5, 1, 4, 3, 0, 1, 0, 1, 0, "R2", "R7");
    xfer(1, 0, 3'd0, 1, 16'hBEEF, 16'h0000, 3, 2, 1, 0, 1, 0, 1, 0, "R2", "R7");
    xfer(1, 0, 3'd3, 0, 16'hA55A, 16'h0000, 2, 2, 2, 0, 1, 0, 1, 0, "R2", "R8");
    xfer(0, 1, 3'd6, 0, 16'h0000, 16'hBEEF, 1, 2, 1, 0, 1, 0, 1, 0, "R2", "R8");
    xfer(1, 1, 3'd5, 1, 16'h0F0F, 16'h0000, 0, 0, 0, 0, 0, 0, 1, 0, "R3", "R7");
    xfer(0, 0, 3'd7, 1, 16'h0000, 16'h8001, 0, 0, 0, 0, 0, 0, 1, 0, "R3", "R9");
    xfer(0, 0, 3'd2, 1, 16'h0000, 16'h6789, 15, 20, 9, 0, 0, 0, 1, 0, "R2", "R9");
    xfer(0, 0, 3'd1, 1, 16'h0000, 16'h4433, 2, 3, 2, 1, 0, 10, 1, 0, "R5", "R9");
    xfer(1, 0, 3'd1, 1, 16'h2211, 16'h0000, 1, 6, 1, 1, 0, 1, 1, 0, "R5", "R7");
    xfer(1, 0, 3'd4, 1, 16'h5566, 16'h0000, 1, 4, 1, 1, 0, 0, 1, 0, "R5", "R7");
    xfer(0, 0, 3'd4, 1, 16'h0000, 16'h7788, 1, 5, 2, 0, 0, 0, 0, 0, "R6", "R9");
    xfer(1, 1, 3'd2, 1, 16'h9ABC, 16'h0000, 2, 4, 2, 0, 0, 0, 1, 1, "R1", "R7");
    chk("R1 rejected request left no cycle", exp_q.size(), 0);
    xfer(0, 0, 3'd3, 1, 16'h0000, 16'hD00D, 1, 2, 1, 0, 0, 0, 1, 0, "R2", "R9");
    xfer(1, 0, 3'd3, 1, 16'hFFFF, 16'h1111, 1, 2, 1, 0, 0, 0, 1, 0, "R2", "R7");
    chk("R9 rdata holds across write", int'(rdata), 16'hD00D);
    repeat (5) @(negedge clk);
    chk("R1 no stray completions", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule